// File: doc/BRIEF.md
# Sequential 32-by-16 Unsigned Divider

This block performs unsigned division for a 16-bit processor's divide instruction. The dividend is 32 bits wide and arrives as a high word and a low word. The divisor is 16 bits wide. The block returns a 16-bit quotient, a 16-bit remainder and an overflow flag. A single-cycle start strobe captures the operands. A single-cycle done pulse marks the point at which the results are valid.

Before any iteration begins, the block tests whether the quotient would fit in one word. The test uses the sign bits of the divisor, of the high dividend word, and of their difference. If the quotient would not fit, which includes a zero divisor, the block performs no division, raises the flag and hands the dividend words back unchanged. Otherwise the block performs one shift-and-subtract step per clock. The remainder forms in the high word and the quotient grows into the low word.

The word width is a parameter (`W`, default 16). The dividend is always two words wide. The step count equals `W`.

Top module: `seqdiv_top`

## Requirements
- R1: After a synchronous active-low reset, `done_o`, `ovf_o`, `quot_o` and `rem_o` are all zero.
- R2: An accepted start raises `ovf_o` exactly when the high dividend word is greater than or equal to the divisor. A zero divisor therefore always overflows.
- R3: On overflow, `done_o` is high in the first cycle after the start edge. `quot_o` then equals the low dividend word and `rem_o` equals the high dividend word.
- R4: Without overflow, `ovf_o` is 0. `quot_o` equals the integer quotient of the 2W-bit dividend (high word in the upper half) by the divisor, and `rem_o` equals the remainder, which is less than the divisor.
- R5: Without overflow, `done_o` first goes high W cycles after the start edge (16 with the default width), and it stays high for exactly one cycle.
- R6: A start that arrives while a division is in progress is ignored. The running division finishes with its original result and timing.
- R7: After `done_o`, the results and `ovf_o` hold their values until the next accepted start.
- R8: The operands are sampled only on an accepted start. Changes on the operand inputs afterwards do not affect the result.
- R9: A start in the cycle where `done_o` is high is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a division |
| dvd_hi_i | input | W | Upper word of the dividend |
| dvd_lo_i | input | W | Lower word of the dividend |
| dvsr_i | input | W | Divisor |
| done_o | output | 1 | One-cycle pulse when results are valid |
| quot_o | output | W | Quotient, or the low dividend word on overflow |
| rem_o | output | W | Remainder, or the high dividend word on overflow |
| ovf_o | output | 1 | Overflow: the quotient would not fit in W bits |

## Verification
Each step depends on the one before it. A single wrong bit in the partial remainder, or a missed subtraction, therefore corrupts every later quotient bit and the final remainder. Such faults appear as wrong values on `quot_o` and `rem_o` at the done pulse, at most W cycles after the start.

An off-by-one in the step counter moves the done pulse by a cycle. It also shifts the quotient by one position. A wrong overflow decision shows in the very first cycle after the start, as a done pulse that arrives too early or too late.

The bench sweeps every operand combination of a 4-bit instance. It also runs a full-width instance through boundary operands.

// File: rtl/seqdiv_pkg.sv
// Package: shared constants for the sequential divider.
// Assumes: consumers take W from their own parameter; this only supplies the default.
package seqdiv_pkg;
    parameter int unsigned SEQDIV_W_DEFAULT = 16;
endpackage

// File: rtl/seqdiv_ovf_check.sv
// Module: overflow predictor.
// Decides from sign bits whether the quotient of {hi, lo} / dvsr would exceed W bits.
// Assumes: unsigned operands; result is purely combinational.
module seqdiv_ovf_check #(
    parameter int unsigned W = seqdiv_pkg::SEQDIV_W_DEFAULT
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] dvsr_i,
    output logic         ovf_o
);
    logic diff_neg;
    logic hi_top;
    logic dv_top;

    // Purpose: pick out the sign bits that the decision uses.
    always_comb begin
        hi_top   = hi_i[W-1];
        dv_top   = dvsr_i[W-1];
        diff_neg = ((hi_i - dvsr_i) >> (W - 1)) != '0;
    end

    // Purpose: overflow when the high word is at least the divisor, found from the signs.
    always_comb begin
        ovf_o = (!dv_top && hi_top) || ((dv_top == hi_top) && !diff_neg);
    end
endmodule

// File: rtl/seqdiv_step.sv
// Module: one restoring shift-and-subtract step.
// Shifts {rem, quo} left by one, then subtracts the divisor when that fits,
// and sets the new quotient bit.
// Assumes: rem_i < dvsr_i on entry, so the updated remainder fits in W bits.
module seqdiv_step #(
    parameter int unsigned W = seqdiv_pkg::SEQDIV_W_DEFAULT
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0]   shifted;
    logic [W-1:0] reduced;
    logic         fits;

    // Purpose: form the (W+1)-bit shifted remainder and its trial difference.
    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        fits    = shifted >= {1'b0, dvsr_i};
        reduced = shifted[W-1:0] - dvsr_i;
    end

    // Purpose: choose the restored or the reduced remainder and insert the quotient bit.
    always_comb begin
        rem_o = fits ? reduced : shifted[W-1:0];
        quo_o = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/seqdiv_ctrl.sv
// Module: sequencing for the divider.
// Accepts a start when idle, counts W steps (the first one on the accept edge),
// and pulses done either at once on overflow or after the last step.
// Assumes: W >= 2.
module seqdiv_ctrl #(
    parameter int unsigned W = seqdiv_pkg::SEQDIV_W_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ovf_now_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    logic [CW-1:0] step_cnt;

    // Purpose: a start is taken only while idle.
    always_comb begin
        accept_o = start_i && !busy_o;
    end

    // Purpose: advance the busy/done state and the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            step_cnt <= '0;
        end else if (accept_o) begin
            step_cnt <= CW'(1);
            busy_o   <= !ovf_now_i;
            done_o   <= ovf_now_i;
        end else if (busy_o) begin
            step_cnt <= step_cnt + CW'(1);
            if (step_cnt == LAST_CNT) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
            end else begin
                done_o <= 1'b0;
            end
        end else begin
            done_o <= 1'b0;
        end
    end

    // R5: the counter never rests at zero while a division runs
    p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (step_cnt != '0));
    // R5: done never overlaps a running division
    p_busy_no_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);
    // R5: the final step ends the run with a done pulse
    p_last_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_cnt == LAST_CNT) |=> (done_o && !busy_o));
endmodule

// File: rtl/seqdiv_top.sv
// Module: sequential unsigned divider, 2W-bit dividend by W-bit divisor.
// Predicts overflow at the start, then performs W restoring steps, one per clock.
// The high register becomes the remainder and the low register the quotient.
// Assumes: start_i is a one-cycle request; operands are valid while it is high.
module seqdiv_top #(
    parameter int unsigned W = seqdiv_pkg::SEQDIV_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dvd_hi_i,
    input  logic [W-1:0] dvd_lo_i,
    input  logic [W-1:0] dvsr_i,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         ovf_o
);
    logic         accept;
    logic         busy;
    logic         ovf_now;
    logic [W-1:0] hi_r;
    logic [W-1:0] lo_r;
    logic [W-1:0] dvsr_r;
    logic         ovf_r;
    logic [W-1:0] step_rem_in;
    logic [W-1:0] step_quo_in;
    logic [W-1:0] step_dvsr;
    logic [W-1:0] step_rem;
    logic [W-1:0] step_quo;

    seqdiv_ovf_check #(.W(W)) u_ovf (
        .hi_i   (dvd_hi_i),
        .dvsr_i (dvsr_i),
        .ovf_o  (ovf_now)
    );

    seqdiv_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ovf_now_i (ovf_now),
        .accept_o  (accept),
        .busy_o    (busy),
        .done_o    (done_o)
    );

    // Purpose: feed the step from the ports on the accept edge and from the registers afterwards.
    always_comb begin
        step_rem_in = busy ? hi_r   : dvd_hi_i;
        step_quo_in = busy ? lo_r   : dvd_lo_i;
        step_dvsr   = busy ? dvsr_r : dvsr_i;
    end

    seqdiv_step #(.W(W)) u_step (
        .rem_i  (step_rem_in),
        .quo_i  (step_quo_in),
        .dvsr_i (step_dvsr),
        .rem_o  (step_rem),
        .quo_o  (step_quo)
    );

    // Purpose: hold the working words, the captured divisor and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_r   <= '0;
            lo_r   <= '0;
            dvsr_r <= '0;
            ovf_r  <= 1'b0;
        end else if (accept) begin
            dvsr_r <= dvsr_i;
            ovf_r  <= ovf_now;
            if (ovf_now) begin
                hi_r <= dvd_hi_i;
                lo_r <= dvd_lo_i;
            end else begin
                hi_r <= step_rem;
                lo_r <= step_quo;
            end
        end else if (busy) begin
            hi_r <= step_rem;
            lo_r <= step_quo;
        end
    end

    // Purpose: present the working words as results.
    always_comb begin
        quot_o = lo_r;
        rem_o  = hi_r;
        ovf_o  = ovf_r;
    end

    // R2: the sign-bit prediction agrees with a plain magnitude comparison
    p_ovf_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ovf_o == ($past(dvd_hi_i) >= $past(dvsr_i))));
    // R3: an overflowing start finishes on the very next cycle with operands returned
    p_ovf_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ovf_now) |=> (done_o && quot_o == $past(dvd_lo_i) && rem_o == $past(dvd_hi_i)));
    // R4: a completed division leaves a remainder below the divisor
    p_rem_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o) |-> (rem_o < dvsr_r));
    // R4: the partial remainder stays below the divisor throughout the run
    p_partial_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (hi_r < dvsr_r));
    // R6: a start while busy leaves the captured divisor alone
    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> $stable(dvsr_r));
    // R7: idle without a start keeps results steady
    p_hold_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> ($stable(quot_o) && $stable(rem_o) && $stable(ovf_o)));
endmodule

// File: tb/seqdiv_top_tb.sv
// Bench: exhaustive sweep of a 4-bit divider plus full-width boundary cases.
module seqdiv_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int WW = 16;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          s4 = 1'b0;
    logic [NW-1:0] hi4 = '0, lo4 = '0, d4 = '0;
    logic          done4, ovf4;
    logic [NW-1:0] q4, r4;

    logic          s16 = 1'b0;
    logic [WW-1:0] hi16 = '0, lo16 = '0, d16 = '0;
    logic          done16, ovf16;
    logic [WW-1:0] q16, r16;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seqdiv_top #(.W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(s4), .dvd_hi_i(hi4), .dvd_lo_i(lo4),
        .dvsr_i(d4), .done_o(done4), .quot_o(q4), .rem_o(r4), .ovf_o(ovf4)
    );

    seqdiv_top #(.W(WW)) u_dut_w16 (
        .clk(clk), .rst_n(rst_n), .start_i(s16), .dvd_hi_i(hi16), .dvd_lo_i(lo16),
        .dvsr_i(d16), .done_o(done16), .quot_o(q16), .rem_o(r16), .ovf_o(ovf16)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One 4-bit operation; optionally a busy-time start with altered operands (R6, R8).
    task automatic run4(input int hi, input int lo, input int d, input bit interfere);
        int dvd, eq, er, elat, lat;
        bit eovf, got;
        dvd  = hi * (1 << NW) + lo;
        eovf = (hi >= d);
        eq   = eovf ? lo : dvd / d;
        er   = eovf ? hi : dvd % d;
        elat = eovf ? 1 : NW;
        @(negedge clk);
        s4 = 1'b1; hi4 = NW'(hi); lo4 = NW'(lo); d4 = NW'(d);
        lat = 0; got = 1'b0;
        while (!got && lat < NW + 4) begin
            @(negedge clk);
            lat++;
            s4 = 1'b0;
            hi4 = ~hi4; lo4 = lo4 + 1'b1; d4 = d4 ^ NW'(5);
            if (interfere && !eovf && lat == 2) s4 = 1'b1;
            if (done4) got = 1'b1;
        end
        s4 = 1'b0;
        check(lat == elat, eovf ? "R3 latency" : (interfere ? "R6 latency" : "R5 latency"), lat, elat);
        check(ovf4 == eovf, "R2 overflow flag", ovf4, eovf);
        check(int'(q4) == eq, eovf ? "R3 quotient" : (interfere ? "R8 quotient" : "R4 quotient"), q4, eq);
        check(int'(r4) == er, eovf ? "R3 remainder" : (interfere ? "R6 remainder" : "R4 remainder"), r4, er);
        @(negedge clk);
        check(done4 == 1'b0, "R5 single-cycle done", done4, 0);
        check(int'(q4) == eq && int'(r4) == er, "R7 results held", {q4, r4}, (eq << NW) | er);
    endtask

    task automatic run16(input longint hi, input longint lo, input longint d);
        longint dvd, eq, er;
        int elat, lat;
        bit eovf, got;
        dvd  = (hi << WW) | lo;
        eovf = (hi >= d);
        eq   = eovf ? lo : dvd / d;
        er   = eovf ? hi : dvd % d;
        elat = eovf ? 1 : WW;
        @(negedge clk);
        s16 = 1'b1; hi16 = WW'(hi); lo16 = WW'(lo); d16 = WW'(d);
        lat = 0; got = 1'b0;
        while (!got && lat < WW + 4) begin
            @(negedge clk);
            lat++;
            s16 = 1'b0;
            hi16 = ~hi16; d16 = ~d16;
            if (done16) got = 1'b1;
        end
        check(lat == elat, eovf ? "R3 latency W16" : "R5 latency W16", lat, elat);
        check(ovf16 == eovf, "R2 overflow W16", ovf16, eovf);
        check(longint'(q16) == eq, eovf ? "R3 quotient W16" : "R4 quotient W16", q16, eq);
        check(longint'(r16) == er, eovf ? "R3 remainder W16" : "R4 remainder W16", r16, er);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !finished) begin
                finished = 1'b1;
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check(done4 == 0 && ovf4 == 0, "R1 done/ovf after reset", {done4, ovf4}, 0);
        check(q4 == 0 && r4 == 0, "R1 results after reset", {q4, r4}, 0);
        check(done16 == 0 && q16 == 0 && r16 == 0, "R1 full width after reset", {done16, q16, r16}, 0);

        // R2 R3 R4 R5 R6 R7 R8: every 4-bit operand combination
        for (int hi = 0; hi < (1 << NW); hi++)
            for (int lo = 0; lo < (1 << NW); lo++)
                for (int d = 0; d < (1 << NW); d++)
                    run4(hi, lo, d, ((hi + lo + d) % 5) == 0);

        // R9: start in the done cycle is accepted (normal op, then overflow op at once)
        @(negedge clk);
        s4 = 1'b1; hi4 = 4'd2; lo4 = 4'd9; d4 = 4'd7;
        @(negedge clk);
        s4 = 1'b0;
        while (!done4) @(negedge clk);
        check(q4 == 4'd5 && r4 == 4'd6, "R9 first result", {q4, r4}, 8'h56);
        s4 = 1'b1; hi4 = 4'd9; lo4 = 4'd3; d4 = 4'd4;
        @(negedge clk);
        s4 = 1'b0;
        check(done4 && ovf4, "R9 second start accepted", {done4, ovf4}, 3);
        check(q4 == 4'd3 && r4 == 4'd9, "R9 second result", {q4, r4}, 8'h39);

        // full-width boundary cases
        run16(64'hFFFE, 64'hFFFF, 64'hFFFF);
        run16(0, 7, 3);
        run16(5, 1234, 0);
        run16(64'h1234, 64'h5678, 64'h1234);
        run16(64'h8000, 0, 64'h8001);
        run16(64'h7FFF, 64'hFFFF, 64'h8000);
        run16(0, 64'hFFFF, 1);
        run16(64'h0001, 0, 64'hFFFF);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule